// File: doc/BRIEF.md
# Two-Channel Memory-to-Memory Transfer Engine

This block copies data items from one memory-mapped address to another on behalf of software or of peripheral request lines. Two independent channels each hold a source pointer, a destination pointer, a remaining-item count and a control word. Software programs a channel through a small word-addressed register port, arms it, and then either triggers it from the global control word or lets one of the hardware request lines pace it. Each copy is one single-beat read from the source followed by one single-beat write to the destination on a shared bus master port.

Only one channel owns the bus at a time. A two-way arbiter picks the winner either by fixed priority or by alternating turns. A channel in cycle-steal mode performs one copy per request and hands the bus back between copies. A channel in burst mode keeps the bus from its first grant until its count is used up. When the last item of a channel is written, that channel disarms itself and raises its done interrupt, which stays high until software clears it.

Top module: `twin_dma_engine`

## Requirements
- R1: After reset every channel register and the global word read as zero, `bus_req` is low and `irq_done` is 2'b00.
- R2: Word address bit 3 selects the global word, bit 2 the channel, bits 1:0 the channel register (0 source, 1 destination, 2 count, 3 control). Control bits: 1:0 size (0 byte, 1 halfword, 2 or 3 word), 2 burst, 3 source fixed, 4 destination fixed, 5 hardware paced, 11:8 request line select, 15 armed. Global bits: 0 round-robin on write and read, 3:2 software trigger per channel (write only), 5:4 interrupt clear on write and interrupt status on read.
- R3: Each copy reads the source address, then writes the destination address; the written data is the read data with the bits above the item size forced to zero, and `bus_size` carries the size code.
- R4: After each copy the source and destination pointers each advance by 1, 2 or 4 bytes according to the size, except a pointer whose fixed bit is set.
- R5: The count drops by one per copy and a programmed count of 0 performs 65,536 copies; after the last copy the armed bit clears and the channel's `irq_done` bit rises, and writing 1 to its clear bit lowers it.
- R6: In cycle-steal mode each request yields one copy and `bus_req` is low for at least one cycle between two copies.
- R7: In burst mode `bus_req` stays high from the first read until the last write of the channel's count.
- R8: A software trigger sets a pending flag that one copy consumes; triggers arriving while the flag is set are merged into it.
- R9: A hardware-paced channel reacts only to the request line its select field names, and each of its copies pulses its `hw_ack` bit for the write cycle.
- R10: In fixed priority, channel 0 wins when both channels request.
- R11: In round-robin, when both request, the channel granted last loses; after reset channel 1 counts as granted last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| hw_req | input | NUM_HW_REQ | Peripheral request lines, level sensitive |
| hw_ack | output | 2 | Per-channel copy acknowledge for hardware-paced channels |
| irq_done | output | 2 | Per-channel done interrupt |
| bus_req | output | 1 | Bus cycle valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Byte address of the bus cycle |
| bus_size | output | 2 | Item size code of the bus cycle |
| bus_wdata | output | 32 | Right-justified write data |
| bus_rdata | input | 32 | Right-justified read data |
| bus_ack | input | 1 | Bus cycle completion |

## Verification
With a zero-wait bus, a copy triggered by a register write captured at clock edge k reads in the cycle after edge k+1, writes in the cycle after edge k+2, and its pointer, count and interrupt updates are visible after edge k+3; a hardware request seen at an edge is granted at that same edge. The bench therefore lets each stimulus settle for a fixed number of falling edges before reading back registers, logs every write cycle at the falling edge when it is stable, and measures burst and cycle-steal bus ownership by counting high `bus_req` samples and rising edges of `bus_req` over exactly the window where copies are due. Arbitration order is taken from the order of logged destination addresses.

// File: rtl/twin_dma_pkg.sv
`timescale 1ns/1ps
package twin_dma_pkg;

   typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

   localparam int REG_SRC  = 0;
   localparam int REG_DST  = 1;
   localparam int REG_CNT  = 2;
   localparam int REG_CTRL = 3;

   localparam int GB_RR      = 0;
   localparam int GB_TRIG_LO = 2;
   localparam int GB_CLR_LO  = 4;

   typedef struct packed {
      logic       arm;
      logic [3:0] sel;
      logic       hw;
      logic       dfix;
      logic       sfix;
      logic       burst;
      logic [1:0] size;
   } chan_ctrl_t;

   function automatic chan_ctrl_t ctrl_from_word(input logic [31:0] w);
      chan_ctrl_t c;
      c.arm   = w[15];
      c.sel   = w[11:8];
      c.hw    = w[5];
      c.dfix  = w[4];
      c.sfix  = w[3];
      c.burst = w[2];
      c.size  = w[1:0];
      return c;
   endfunction

   function automatic logic [31:0] ctrl_to_word(input chan_ctrl_t c);
      logic [31:0] w;
      w        = '0;
      w[15]    = c.arm;
      w[11:8]  = c.sel;
      w[5]     = c.hw;
      w[4]     = c.dfix;
      w[3]     = c.sfix;
      w[2]     = c.burst;
      w[1:0]   = c.size;
      return w;
   endfunction

   function automatic logic [2:0] size_bytes(input logic [1:0] s);
      case (s)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [31:0] size_mask(input logic [1:0] s);
      case (s)
         2'd0:    return 32'h0000_00FF;
         2'd1:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

endpackage

// File: rtl/twin_dma_chan.sv
`timescale 1ns/1ps
module twin_dma_chan
   import twin_dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int NUM_HW_REQ = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [1:0]            reg_sel,
   input  logic [31:0]           wr_data,
   input  logic                  trig,
   input  logic                  irq_clr,
   input  logic                  xfer_done,
   input  logic [NUM_HW_REQ-1:0] hw_req,
   output logic [ADDR_W-1:0]     src_q,
   output logic [ADDR_W-1:0]     dst_q,
   output logic [CNT_W-1:0]      cnt_q,
   output chan_ctrl_t            ctrl_q,
   output logic                  req,
   output logic                  last,
   output logic                  irq_q,
   output logic [31:0]           rd_data
);

   logic              sw_flag;
   logic              hw_level;
   logic [ADDR_W-1:0] step;

   always_comb begin
      hw_level = 1'b0;
      for (int k = 0; k < NUM_HW_REQ; k++) begin
         if (ctrl_q.sel == 4'(k)) hw_level = hw_req[k];
      end
   end

   assign step = ADDR_W'(size_bytes(ctrl_q.size));
   assign req  = ctrl_q.arm & (ctrl_q.hw ? hw_level : sw_flag);
   assign last = (cnt_q == CNT_W'(1));

   always_comb begin
      case (reg_sel)
         2'd0:    rd_data = 32'(src_q);
         2'd1:    rd_data = 32'(dst_q);
         2'd2:    rd_data = 32'(cnt_q);
         default: rd_data = ctrl_to_word(ctrl_q);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         dst_q   <= '0;
         cnt_q   <= '0;
         ctrl_q  <= '0;
         sw_flag <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (irq_clr) irq_q <= 1'b0;
         if (xfer_done) begin
            if (!ctrl_q.sfix) src_q <= src_q + step;
            if (!ctrl_q.dfix) dst_q <= dst_q + step;
            cnt_q   <= cnt_q - CNT_W'(1);
            sw_flag <= 1'b0;
            if (last) begin
               ctrl_q.arm <= 1'b0;
               irq_q      <= 1'b1;
            end
         end
         if (trig) sw_flag <= 1'b1;
         if (wr_en) begin
            case (reg_sel)
               2'd0:    src_q  <= wr_data[ADDR_W-1:0];
               2'd1:    dst_q  <= wr_data[ADDR_W-1:0];
               2'd2:    cnt_q  <= wr_data[CNT_W-1:0];
               default: ctrl_q <= ctrl_from_word(wr_data);
            endcase
         end
      end
   end

endmodule

// File: rtl/twin_dma_arb.sv
`timescale 1ns/1ps
module twin_dma_arb (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] req,
   input  logic       rr_mode,
   input  logic       take,
   output logic       gnt_ch
);

   logic last_q;

   always_comb begin
      if (req == 2'b11) gnt_ch = rr_mode ? ~last_q : 1'b0;
      else              gnt_ch = ~req[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    last_q <= 1'b1;
      else if (take) last_q <= gnt_ch;
   end

endmodule

// File: rtl/twin_dma_mover.sv
`timescale 1ns/1ps
module twin_dma_mover
   import twin_dma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   any_req,
   input  logic                   gnt_ch,
   input  logic [1:0][ADDR_W-1:0] src_v,
   input  logic [1:0][ADDR_W-1:0] dst_v,
   input  logic [1:0][1:0]        size_v,
   input  logic [1:0]             burst_v,
   input  logic [1:0]             last_v,
   input  logic [31:0]            bus_rdata,
   input  logic                   bus_ack,
   output logic                   bus_req,
   output logic                   bus_we,
   output logic [ADDR_W-1:0]      bus_addr,
   output logic [1:0]             bus_size,
   output logic [31:0]            bus_wdata,
   output logic                   take,
   output logic                   cur_ch,
   output logic [1:0]             xfer_done
);

   mv_state_e   state_q;
   logic [31:0] data_q;

   assign take      = (state_q == MV_IDLE) & any_req;
   assign bus_req   = (state_q != MV_IDLE);
   assign bus_we    = (state_q == MV_WRITE);
   assign bus_addr  = bus_we ? dst_v[cur_ch] : src_v[cur_ch];
   assign bus_size  = size_v[cur_ch];
   assign bus_wdata = data_q;

   always_comb begin
      xfer_done = 2'b00;
      if (state_q == MV_WRITE && bus_ack) xfer_done[cur_ch] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MV_IDLE;
         cur_ch  <= 1'b0;
         data_q  <= '0;
      end else begin
         case (state_q)
            MV_IDLE: if (take) begin
               cur_ch  <= gnt_ch;
               state_q <= MV_READ;
            end
            MV_READ: if (bus_ack) begin
               data_q  <= bus_rdata & size_mask(size_v[cur_ch]);
               state_q <= MV_WRITE;
            end
            MV_WRITE: if (bus_ack) begin
               state_q <= (burst_v[cur_ch] & ~last_v[cur_ch]) ? MV_READ : MV_IDLE;
            end
            default: state_q <= MV_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/twin_dma_engine.sv
`timescale 1ns/1ps
module twin_dma_engine
   import twin_dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int CNT_W      = 16,
   parameter int NUM_HW_REQ = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cfg_we,
   input  logic [3:0]            cfg_addr,
   input  logic [31:0]           cfg_wdata,
   output logic [31:0]           cfg_rdata,
   input  logic [NUM_HW_REQ-1:0] hw_req,
   output logic [1:0]            hw_ack,
   output logic [1:0]            irq_done,
   output logic                  bus_req,
   output logic                  bus_we,
   output logic [ADDR_W-1:0]     bus_addr,
   output logic [1:0]            bus_size,
   output logic [31:0]           bus_wdata,
   input  logic [31:0]           bus_rdata,
   input  logic                  bus_ack
);

   localparam int NUM_CH = 2;

   generate
      if (NUM_HW_REQ < 1 || NUM_HW_REQ > 16) begin : g_bad_req
         $error("NUM_HW_REQ must lie in 1..16");
      end
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
         $error("ADDR_W must lie in 8..32");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 2..16");
      end
   endgenerate

   logic                    glb_sel;
   logic                    rr_mode;
   logic [NUM_CH-1:0]       xfer_done;
   logic [NUM_CH-1:0]       ch_req;
   logic [NUM_CH-1:0]       ch_last;
   logic [NUM_CH-1:0]       ch_burst;
   logic [NUM_CH-1:0]       ch_sfix;
   logic [NUM_CH-1:0]       ch_hw;
   logic [NUM_CH-1:0][ADDR_W-1:0] ch_src;
   logic [NUM_CH-1:0][ADDR_W-1:0] ch_dst;
   logic [NUM_CH-1:0][CNT_W-1:0]  ch_cnt;
   logic [NUM_CH-1:0][1:0]        ch_size;
   logic [NUM_CH-1:0][31:0]       ch_rd;
   logic                    mv_take;
   logic                    mv_gnt;
   logic                    mv_cur;

   assign glb_sel = cfg_addr[3];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      chan_ctrl_t ctrl;
      twin_dma_chan #(
         .ADDR_W    (ADDR_W),
         .CNT_W     (CNT_W),
         .NUM_HW_REQ(NUM_HW_REQ)
      ) chan_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (cfg_we & ~glb_sel & (cfg_addr[2] == 1'(c))),
         .reg_sel  (cfg_addr[1:0]),
         .wr_data  (cfg_wdata),
         .trig     (cfg_we & glb_sel & cfg_wdata[GB_TRIG_LO + c]),
         .irq_clr  (cfg_we & glb_sel & cfg_wdata[GB_CLR_LO + c]),
         .xfer_done(xfer_done[c]),
         .hw_req   (hw_req),
         .src_q    (ch_src[c]),
         .dst_q    (ch_dst[c]),
         .cnt_q    (ch_cnt[c]),
         .ctrl_q   (ctrl),
         .req      (ch_req[c]),
         .last     (ch_last[c]),
         .irq_q    (irq_done[c]),
         .rd_data  (ch_rd[c])
      );
      assign ch_size[c]  = ctrl.size;
      assign ch_burst[c] = ctrl.burst;
      assign ch_sfix[c]  = ctrl.sfix;
      assign ch_hw[c]    = ctrl.hw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 rr_mode <= 1'b0;
      else if (cfg_we && glb_sel) rr_mode <= cfg_wdata[GB_RR];
   end

   always_comb begin
      if (glb_sel) begin
         cfg_rdata            = '0;
         cfg_rdata[GB_RR]     = rr_mode;
         cfg_rdata[GB_CLR_LO +: 2] = irq_done;
      end else begin
         cfg_rdata = ch_rd[cfg_addr[2]];
      end
   end

   twin_dma_arb arb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (ch_req),
      .rr_mode(rr_mode),
      .take   (mv_take),
      .gnt_ch (mv_gnt)
   );

   twin_dma_mover #(.ADDR_W(ADDR_W)) mover_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_req  (|ch_req),
      .gnt_ch   (mv_gnt),
      .src_v    (ch_src),
      .dst_v    (ch_dst),
      .size_v   (ch_size),
      .burst_v  (ch_burst),
      .last_v   (ch_last),
      .bus_rdata(bus_rdata),
      .bus_ack  (bus_ack),
      .bus_req  (bus_req),
      .bus_we   (bus_we),
      .bus_addr (bus_addr),
      .bus_size (bus_size),
      .bus_wdata(bus_wdata),
      .take     (mv_take),
      .cur_ch   (mv_cur),
      .xfer_done(xfer_done)
   );

   assign hw_ack = xfer_done & ch_hw;

endmodule

// File: rtl/twin_dma_chk.sv
`timescale 1ns/1ps
module twin_dma_chk
   import twin_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   bus_req,
   input logic                   bus_we,
   input logic                   bus_ack,
   input logic [1:0]             irq_done,
   input logic [1:0]             hw_ack,
   input logic [1:0]             done,
   input logic [1:0][CNT_W-1:0]  cnt,
   input logic [1:0][ADDR_W-1:0] src,
   input logic [1:0][1:0]        size,
   input logic [1:0]             sfix,
   input logic [1:0]             burst,
   input logic [1:0]             last,
   input logic                   cur_ch,
   input logic                   take,
   input logic                   rr,
   input logic [1:0]             req,
   input logic                   gnt
);

   logic [ADDR_W-1:0] step0;
   assign step0 = ADDR_W'(size_bytes(size[0]));

   p_write_in_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we |-> bus_req);

   p_src_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      done[0] && !sfix[0] |=> src[0] == $past(src[0]) + $past(step0));

   p_cnt_step0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done[0] |=> cnt[0] == $past(cnt[0]) - CNT_W'(1));

   p_cnt_step1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done[1] |=> cnt[1] == $past(cnt[1]) - CNT_W'(1));

   p_irq_cause0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_done[0]) |-> $past(done[0] && last[0]));

   p_irq_cause1_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_done[1]) |-> $past(done[1] && last[1]));

   p_steal_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_ack && !burst[cur_ch] |=> !bus_req);

   p_burst_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_we && bus_ack && burst[cur_ch] && !last[cur_ch] |=> bus_req && !bus_we);

   p_ack_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hw_ack));

   p_fixed_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
      take && !rr && req == 2'b11 |=> cur_ch == 1'b0);

endmodule

bind twin_dma_engine twin_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .bus_req (bus_req),
   .bus_we  (bus_we),
   .bus_ack (bus_ack),
   .irq_done(irq_done),
   .hw_ack  (hw_ack),
   .done    (xfer_done),
   .cnt     (ch_cnt),
   .src     (ch_src),
   .size    (ch_size),
   .sfix    (ch_sfix),
   .burst   (ch_burst),
   .last    (ch_last),
   .cur_ch  (mv_cur),
   .take    (mv_take),
   .rr      (rr_mode),
   .req     (ch_req),
   .gnt     (mv_gnt)
);

// File: tb/twin_dma_engine_tb_top.sv
`timescale 1ns/1ps
module twin_dma_engine_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [3:0]  hw_req;
   logic [1:0]  hw_ack;
   logic [1:0]  irq_done;
   logic        bus_req, bus_we, bus_ack;
   logic [31:0] bus_addr, bus_wdata, bus_rdata;
   logic [1:0]  bus_size;

   int given [4];
   int taken [4];
   logic [3:0] hw_force = '0;
   int line_of [2];

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit finished = 0;

   logic [31:0] log_addr [64];
   logic [31:0] log_data [64];
   int wr_total = 0;
   int rise_cnt = 0;
   int ack_cnt [2];
   logic prev_req = 1'b0;

   always #2 clk = ~clk;

   twin_dma_engine dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hw_req(hw_req),
      .hw_ack(hw_ack), .irq_done(irq_done), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .bus_ack(bus_ack)
   );

   function automatic logic [31:0] pat(input logic [31:0] a);
      return {~a[15:0], a[15:0] ^ 16'h5A3C};
   endfunction

   function automatic logic [31:0] msk(input int sz);
      return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
   endfunction

   function automatic logic [31:0] mk_ctrl(input int sz, input bit burst, input bit sfix,
                                           input bit dfix, input bit hw, input int sel);
      logic [31:0] w = '0;
      w[1:0]  = 2'(sz);
      w[2]    = burst;
      w[3]    = sfix;
      w[4]    = dfix;
      w[5]    = hw;
      w[11:8] = 4'(sel);
      w[15]   = 1'b1;
      return w;
   endfunction

   assign bus_ack   = bus_req;
   assign bus_rdata = pat(bus_addr);

   always_comb begin
      for (int k = 0; k < 4; k++) hw_req[k] = (given[k] != taken[k]) | hw_force[k];
   end

   always @(negedge clk) begin
      if (bus_req && !prev_req) rise_cnt <= rise_cnt + 1;
      prev_req <= bus_req;
      if (bus_req && bus_we) begin
         if (wr_total < 64) begin
            log_addr[wr_total] <= bus_addr;
            log_data[wr_total] <= bus_wdata;
         end
         wr_total <= wr_total + 1;
      end
      for (int c = 0; c < 2; c++) begin
         if (hw_ack[c]) begin
            taken[line_of[c]] <= taken[line_of[c]] + 1;
            ack_cnt[c]        <= ack_cnt[c] + 1;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      @(negedge clk);
      d = cfg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic prog(input int c, input logic [31:0] s, input logic [31:0] d,
                       input logic [31:0] n, input logic [31:0] ctl);
      wr({1'b0, 1'(c), 2'd0}, s);
      wr({1'b0, 1'(c), 2'd1}, d);
      wr({1'b0, 1'(c), 2'd2}, n);
      wr({1'b0, 1'(c), 2'd3}, ctl);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 195000 && !finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog all actual=%0d expected=<195000", cyc);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int base, r0, hi, w0;
      for (int k = 0; k < 4; k++) begin given[k] = 0; taken[k] = 0; end
      ack_cnt[0] = 0; ack_cnt[1] = 0;
      line_of[0] = 0; line_of[1] = 0;
      idle(3);
      rst_n = 1'b1;
      idle(2);

      // R1: reset state
      for (int a = 0; a < 9; a++) begin
         rd(4'(a), v);
         chk("R1 reg reset", v, 32'h0);
      end
      chk("R1 bus_req reset", {31'b0, bus_req}, 32'h0);
      chk("R1 irq reset", {30'b0, irq_done}, 32'h0);

      // R2 R3 R4 R5: software cycle-steal, 32-bit, both pointers advance
      prog(0, 32'h100, 32'h800, 32'd3, mk_ctrl(2, 0, 0, 0, 0, 0));
      rd(4'd3, v);
      chk("R2 ctrl readback", v, mk_ctrl(2, 0, 0, 0, 0, 0));
      base = wr_total;
      for (int t = 0; t < 3; t++) begin
         wr(4'b1000, 32'h4);
         idle(6);
      end
      chk("R6 one copy per trigger", 32'(wr_total - base), 32'd3);
      for (int t = 0; t < 3; t++) begin
         chk("R3 dst addr", log_addr[base + t], 32'h800 + 32'(4 * t));
         chk("R3 data word", log_data[base + t], pat(32'h100 + 32'(4 * t)));
      end
      rd(4'd0, v); chk("R4 src advanced by 4s", v, 32'h10C);
      rd(4'd2, v); chk("R5 count empty", v, 32'h0);
      rd(4'd3, v); chk("R5 armed cleared", v, mk_ctrl(2, 0, 0, 0, 0, 0) & ~32'h8000);
      chk("R5 irq raised", {30'b0, irq_done}, 32'h1);
      rd(4'b1000, v); chk("R2 global irq status", v & 32'h30, 32'h10);
      wr(4'b1000, 32'h10);
      idle(1);
      chk("R5 irq cleared", {30'b0, irq_done}, 32'h0);

      // R8 R4 R3: byte copies, fixed source, merged triggers
      prog(1, 32'h200, 32'h300, 32'd5, mk_ctrl(0, 0, 1, 0, 0, 0));
      base = wr_total;
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'b1000; cfg_wdata = 32'h8;
      @(negedge clk);
      @(negedge clk);
      cfg_we = 1'b0;
      idle(6);
      chk("R8 merged triggers give one copy", 32'(wr_total - base), 32'd1);
      wr(4'b1000, 32'h8);
      idle(6);
      chk("R8 next trigger copies", 32'(wr_total - base), 32'd2);
      chk("R3 byte data", log_data[base + 1], pat(32'h200) & msk(0));
      chk("R4 byte dst step", log_addr[base + 1], 32'h301);
      rd(4'd4, v); chk("R4 fixed src held", v, 32'h200);
      rd(4'd5, v); chk("R4 dst step 1", v, 32'h302);
      rd(4'd6, v); chk("R5 count 3 left", v, 32'd3);
      wr(4'd7, 32'h0);

      // R7 R4: burst, halfword, fixed destination
      prog(0, 32'h400, 32'h900, 32'd4, mk_ctrl(1, 1, 0, 1, 0, 0));
      base = wr_total; r0 = rise_cnt;
      wr(4'b1000, 32'h4);
      hi = 0;
      for (int t = 0; t < 8; t++) begin
         @(negedge clk);
         hi += int'(bus_req);
      end
      chk("R7 bus held for whole burst", 32'(hi), 32'd8);
      @(negedge clk);
      chk("R7 bus released after burst", {31'b0, bus_req}, 32'h0);
      chk("R7 single bus ownership", 32'(rise_cnt - r0), 32'd1);
      for (int t = 0; t < 4; t++) begin
         chk("R4 fixed dst", log_addr[base + t], 32'h900);
         chk("R3 halfword data", log_data[base + t], pat(32'h400 + 32'(2 * t)) & msk(1));
      end
      rd(4'd0, v); chk("R4 src step 2", v, 32'h408);

      // R9 R6: hardware paced, line select
      line_of[1] = 2;
      prog(1, 32'h600, 32'hB00, 32'd3, mk_ctrl(2, 0, 0, 0, 1, 2));
      base = wr_total;
      hw_force = 4'b0010;
      idle(10);
      chk("R9 other line ignored", 32'(wr_total - base), 32'd0);
      rd(4'd6, v); chk("R9 count untouched", v, 32'd3);
      hw_force = 4'b0000;
      r0 = rise_cnt;
      w0 = ack_cnt[1];
      given[2] = given[2] + 3;
      idle(16);
      chk("R9 copies on selected line", 32'(wr_total - base), 32'd3);
      chk("R9 ack pulses", 32'(ack_cnt[1] - w0), 32'd3);
      chk("R6 bus released between copies", 32'(rise_cnt - r0), 32'd3);
      chk("R9 dst order", log_addr[base + 2], 32'hB08);

      // R10: fixed priority with both lines held
      wr(4'b1000, 32'h30);
      line_of[0] = 0; line_of[1] = 3;
      prog(0, 32'h1000, 32'h2000, 32'd2, mk_ctrl(2, 0, 0, 0, 1, 0));
      prog(1, 32'h1100, 32'h2100, 32'd2, mk_ctrl(2, 0, 0, 0, 1, 3));
      base = wr_total;
      @(negedge clk);
      given[0] = given[0] + 2; given[3] = given[3] + 2;
      idle(20);
      chk("R10 first", log_addr[base + 0], 32'h2000);
      chk("R10 second", log_addr[base + 1], 32'h2004);
      chk("R10 third", log_addr[base + 2], 32'h2100);
      chk("R10 fourth", log_addr[base + 3], 32'h2104);

      // R11: round-robin, channel 1 granted last
      wr(4'b1000, 32'h1);
      rd(4'b1000, v); chk("R2 rr mode readback", v & 32'h1, 32'h1);
      prog(0, 32'h1000, 32'h3000, 32'd2, mk_ctrl(2, 0, 0, 0, 1, 0));
      prog(1, 32'h1100, 32'h3100, 32'd2, mk_ctrl(2, 0, 0, 0, 1, 3));
      base = wr_total;
      @(negedge clk);
      given[0] = given[0] + 2; given[3] = given[3] + 2;
      idle(20);
      chk("R11 first", log_addr[base + 0], 32'h3000);
      chk("R11 second", log_addr[base + 1], 32'h3100);
      chk("R11 third", log_addr[base + 2], 32'h3004);
      chk("R11 fourth", log_addr[base + 3], 32'h3104);

      // R5: count 0 means 65536 copies
      wr(4'b1000, 32'h31);
      idle(1);
      chk("R5 irq clear both", {30'b0, irq_done}, 32'h0);
      prog(1, 32'h40, 32'h80, 32'd0, mk_ctrl(2, 1, 1, 1, 0, 0));
      base = wr_total; r0 = rise_cnt;
      wr(4'b1000, 32'h9);
      for (int g = 0; g < 140000 && !irq_done[1]; g++) @(negedge clk);
      idle(2);
      chk("R5 65536 copies", 32'(wr_total - base), 32'd65536);
      chk("R7 one ownership for full count", 32'(rise_cnt - r0), 32'd1);
      rd(4'd6, v); chk("R5 count wrapped to 0", v, 32'h0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule